// File: doc/BRIEF.md
# Adjustable Microframe Start-of-Frame Timer

This block produces a start-of-frame strobe once per microframe. The microframe length is counted in timer clock periods. It is not fixed: it is a base of 59488 clocks plus 16 clocks for each unit of a 6-bit adjustment value. Software holds that value in a small byte-wide register window. At its reset value of 32 the length is exactly 60000 clocks.

The register window has two byte locations. Offset 61h holds the adjustment value. Offset 60h is a fixed read-only byte that reports the bus release number, 20h. Reads are combinational from the offset. Writes take effect at the next clock edge.

The timer runs only while `run` is high. It reports its current position in the frame on `frame_count`. A value written to the adjustment register while a frame is in progress is applied only from the next microframe boundary. The frame in progress therefore always keeps the length it started with.

Top module: `sof_timer_top`

## Requirements
- R1: One microframe lasts 59488 + 16·A timer clocks, where A is the 6-bit adjustment value in force for that frame. Within a frame `frame_count` runs from 0 up to that length minus 1.
- R2: While the synchronous active-high `rst` is high, and in the first cycle after it, the adjustment value is 32, `frame_count` is 0 and `sof_pulse` is low. The first frame after reset is 60000 clocks long.
- R3: Offset 61h is the adjustment register. A write stores `reg_wdata[5:0]` as the new value, and a read at 61h returns it in bits 5..0 from the cycle after the write.
- R4: Bits 7..6 of a read at offset 61h are always 0, whatever was written to them.
- R5: A read at offset 60h returns 20h. Writes to 60h change neither that byte nor the adjustment value.
- R6: A value written during a frame does not change that frame's length. The value takes effect from the next microframe boundary.
- R7: `sof_pulse` is high for exactly one cycle, the cycle in which `frame_count` has just wrapped to 0. It is never high otherwise.
- R8: While `run` is low, `frame_count` is held at 0 and `sof_pulse` stays low. After `run` is raised, the first pulse appears one full microframe later, which is L clock edges for a length L.
- R9: A read at any offset other than 60h or 61h returns 00h, and a write there has no effect on any register.
- R10: `frame_count` shows the timer's position, advancing by one per clock while `run` is high and the frame has not ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (one SOF-counter period per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable; low holds the timer at 0 |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr`, combinational |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| frame_count | output | 16 | Current position within the microframe |

## Verification
Reads are combinational, so read data is sampled in the same cycle the offset is driven. A written value becomes visible one clock edge after the write strobe. The timer outputs are registered: `frame_count` and `sof_pulse` change on the edge after the inputs that cause them, and a new length appears only in the frame after the one in which it was written. The bench drives inputs on the falling edge. A behavioural model steps on each rising edge and is compared with the outputs on every falling edge. Explicit edge counts between pulses confirm the 60000-clock and 59488-clock frame lengths and the one-frame delay of a mid-frame write.

// File: rtl/sof_pkg.sv
package sof_pkg;

  // Microframe length in timer clocks for a given adjustment value.
  function automatic int unsigned frame_len(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned adj);
    return base + step * adj;
  endfunction

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_REL  = 2'd1,
    SEL_ADJ  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/sof_cfg_regs.sv
module sof_cfg_regs #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADJ_W     = 6,
  parameter int unsigned ADJ_RESET = 32,
  parameter int unsigned REL_ADDR  = 'h60,
  parameter int unsigned ADJ_ADDR  = 'h61,
  parameter int unsigned REL_VALUE = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ADJ_W-1:0]  adj
);
  import sof_pkg::*;

  localparam int unsigned RSV_W = DATA_W - ADJ_W;

  reg_sel_e         sel;
  logic             adj_wr_evt;
  logic [ADJ_W-1:0] adj_q;

  always_comb begin
    if (addr == ADDR_W'(ADJ_ADDR))      sel = SEL_ADJ;
    else if (addr == ADDR_W'(REL_ADDR)) sel = SEL_REL;
    else                                sel = SEL_NONE;
  end

  assign adj_wr_evt = wr && (sel == SEL_ADJ);

  always_ff @(posedge clk) begin
    if (rst)             adj_q <= ADJ_W'(ADJ_RESET);
    else if (adj_wr_evt) adj_q <= wdata[ADJ_W-1:0];
  end

  always_comb begin
    unique case (sel)
      SEL_ADJ: rdata = {{RSV_W{1'b0}}, adj_q};
      SEL_REL: rdata = DATA_W'(REL_VALUE);
      default: rdata = '0;
    endcase
  end

  assign adj = adj_q;

  assert_adj_write_R3: assert property (@(posedge clk) disable iff (rst)
    adj_wr_evt |=> adj_q == $past(wdata[ADJ_W-1:0]));
  assert_adj_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !adj_wr_evt |=> $stable(adj_q));
  assert_rsv_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(ADJ_ADDR)) |-> rdata[DATA_W-1:ADJ_W] == '0);
  assert_rel_const_R5: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(REL_ADDR)) |-> rdata == DATA_W'(REL_VALUE));
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (addr != ADDR_W'(REL_ADDR) && addr != ADDR_W'(ADJ_ADDR)) |-> rdata == '0);

endmodule

// File: rtl/sof_frame_counter.sv
module sof_frame_counter #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADJ_W     = 6,
  parameter int unsigned BASE_LEN  = 59488,
  parameter int unsigned STEP_LEN  = 16,
  parameter int unsigned ADJ_RESET = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [ADJ_W-1:0] adj,
  output logic [CNT_W-1:0] count,
  output logic             sof_pulse,
  output logic             wrap_evt
);
  import sof_pkg::*;

  localparam logic [CNT_W-1:0] RESET_LEN = CNT_W'(frame_len(BASE_LEN, STEP_LEN, ADJ_RESET));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] next_len;
  logic             pulse_q;
  logic             at_last;

  assign next_len = CNT_W'(frame_len(BASE_LEN, STEP_LEN, 32'(adj)));
  assign at_last  = (cnt_q == len_q - 1'b1);
  assign wrap_evt = run && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      len_q   <= RESET_LEN;
      pulse_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      len_q   <= next_len;
      pulse_q <= 1'b0;
    end else if (at_last) begin
      cnt_q   <= '0;
      len_q   <= next_len;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign count     = cnt_q;
  assign sof_pulse = pulse_q;

  assert_cnt_in_frame_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q < len_q);
  assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> cnt_q == '0);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0) && !pulse_q);
  assert_len_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap_evt) |=> $stable(len_q));
  assert_wrap_pulses_R7: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> pulse_q);

endmodule

// File: rtl/sof_timer_top.sv
module sof_timer_top #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADJ_W     = 6,
  parameter int unsigned BASE_LEN  = 59488,
  parameter int unsigned STEP_LEN  = 16,
  parameter int unsigned ADJ_RESET = 32,
  parameter int unsigned REL_ADDR  = 'h60,
  parameter int unsigned ADJ_ADDR  = 'h61,
  parameter int unsigned REL_VALUE = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sof_pulse,
  output logic [CNT_W-1:0]  frame_count
);

  logic [ADJ_W-1:0] adj_val;
  logic             wrap_evt;

  sof_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADJ_W(ADJ_W), .ADJ_RESET(ADJ_RESET),
    .REL_ADDR(REL_ADDR), .ADJ_ADDR(ADJ_ADDR), .REL_VALUE(REL_VALUE)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata), .adj(adj_val)
  );

  sof_frame_counter #(
    .CNT_W(CNT_W), .ADJ_W(ADJ_W), .BASE_LEN(BASE_LEN),
    .STEP_LEN(STEP_LEN), .ADJ_RESET(ADJ_RESET)
  ) cnt_i (
    .clk(clk), .rst(rst), .run(run), .adj(adj_val),
    .count(frame_count), .sof_pulse(sof_pulse), .wrap_evt(wrap_evt)
  );

  assert_reset_idle_R2: assert property (@(posedge clk)
    $past(rst) |-> (frame_count == '0) && !sof_pulse);

endmodule

// File: tb/sof_timer_top_tb_top.sv
module sof_timer_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sof_pulse;
  logic [15:0] frame_count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0, m_len = 60000, m_adj = 32;
  bit m_pulse = 0;

  always #4 clk = ~clk; // 125 MHz

  sof_timer_top dut_i (
    .clk(clk), .rst(rst), .run(run), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof_pulse(sof_pulse),
    .frame_count(frame_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model: steps on each rising edge from the inputs the bench drove
  always @(posedge clk) begin
    int old_adj;
    old_adj = m_adj;
    if (rst) begin
      m_cnt = 0; m_adj = 32; m_len = 59488 + 16 * 32; m_pulse = 0;
    end else begin
      if (reg_wr && reg_addr == 8'h61) m_adj = reg_wdata % 64;
      if (!run) begin
        m_cnt = 0; m_pulse = 0; m_len = 59488 + 16 * old_adj;
      end else if (m_cnt == m_len - 1) begin
        m_cnt = 0; m_pulse = 1; m_len = 59488 + 16 * old_adj;
      end else begin
        m_cnt++; m_pulse = 0;
      end
    end
  end

  // per-cycle comparison (R1, R7, R8, R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(frame_count) == m_cnt, "R10 count vs model", frame_count, m_cnt);
      check(sof_pulse == m_pulse, "R7 pulse vs model", sof_pulse, m_pulse);
    end
  end

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R2 reset values
    check(frame_count == 16'd0, "R2 count in reset", frame_count, 0);
    check(sof_pulse == 1'b0, "R2 pulse in reset", sof_pulse, 0);
    rst = 1'b0;
    @(negedge clk);
    rd_check(8'h61, 8'h20, "R2 adj reset value");
    rd_check(8'h60, 8'h20, "R5 release byte");
    check(frame_count == 16'd0, "R2 count after reset", frame_count, 0);

    // R3, R4 register access
    wr_byte(8'h61, 8'hFF);
    rd_check(8'h61, 8'h3F, "R4 reserved bits read 0 after all-ones write");
    wr_byte(8'h61, 8'hC5);
    rd_check(8'h61, 8'h05, "R3 adj readback 05h");
    // R5 write to release byte ignored
    wr_byte(8'h60, 8'h00);
    rd_check(8'h60, 8'h20, "R5 release byte after write");
    rd_check(8'h61, 8'h05, "R5 adj untouched by 60h write");
    // R9 unmapped
    wr_byte(8'h62, 8'hFF);
    rd_check(8'h62, 8'h00, "R9 unmapped read");
    rd_check(8'h61, 8'h05, "R9 adj untouched by unmapped write");
    rd_check(8'h5F, 8'h00, "R9 unmapped read below window");
    wr_byte(8'h61, 8'h20);
    rd_check(8'h61, 8'h20, "R3 adj restored");

    // R8 short run then stop
    run = 1'b1;
    repeat (50) @(negedge clk);
    check(frame_count == 16'd50, "R10 count after 50 edges", frame_count, 50);
    run = 1'b0;
    @(negedge clk);
    check(frame_count == 16'd0, "R8 count held at 0 when stopped", frame_count, 0);
    repeat (5) @(negedge clk);
    check(frame_count == 16'd0 && !sof_pulse, "R8 idle stays 0", frame_count, 0);

    // R8/R2/R1 first frame 60000; mid-frame write of 0 (R6)
    run = 1'b1;
    n = 0;
    do begin
      if (n == 1000) begin
        reg_addr = 8'h61; reg_wdata = 8'h00; reg_wr = 1'b1;
      end
      @(negedge clk);
      reg_wr = 1'b0;
      n++;
    end while (!sof_pulse && n < 70000);
    check(n == 60000, "R6 first frame keeps 60000 after mid-frame write", n, 60000);
    rd_check(8'h61, 8'h00, "R3 adj readback 00h");

    // R1 next frame uses the new value: 59488
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sof_pulse && n < 70000);
    check(n == 59488, "R1 frame length with adj 0", n, 59488);
    @(negedge clk);
    check(!sof_pulse, "R7 pulse lasts one cycle", sof_pulse, 0);
    check(frame_count == 16'd1, "R10 count restarts", frame_count, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule